// File: doc/BRIEF.md
# Write-Once Protected Clock-Source Select Register

This block holds the 2-bit selection that decides which oscillator drives a watch timer and a display controller. Software reaches it over a small register bus with an address, a write strobe, write data and combinational read data. A write lands in the select register only if two conditions hold. First, it must follow an unlock step: the key value 8'hA5 is written to a command register, and the select register must be the next bus write. Second, the one permitted write since the last reset must not have been used yet. After that first sequenced write, the register locks until the next reset.

A sticky error flag records broken unlock sequences. A sequenced write that reaches an already locked register is dropped without raising the flag, so the flag reflects sequence violations only. The block drives the select code, a locked indication and the error flag as outputs. It does no clock switching itself.

The unlock tracking is a two-state machine. In state SEQ_IDLE, a key write moves it to SEQ_ARMED (transition KEY_OK). A select write in SEQ_IDLE raises the error flag (transition BARE_WRITE). In SEQ_ARMED, every bus write returns the machine to SEQ_IDLE. If that write targets the select register, it is a commit attempt (transition COMMIT). A write to any other offset is an error (transition ABORT). Reads never move the machine.

Top module: `clksel_protect`

## Requirements
- R1: While reset is asserted, and right after it is released, the select output is 00, the locked output is 0 and the error flag is 0.
- R2: The sequence is: a write of 8'hA5 to offset 0, then a write to offset 1 as the next bus write. This sequence copies write data bits [1:0] into the select output and sets the locked output to 1.
- R3: A write to offset 1 without a directly preceding key write leaves the select and locked outputs unchanged and sets the error flag to 1.
- R4: After a key write, a next bus write to any offset other than 1 does three things. It cancels the unlock, it sets the error flag, and it leaves the following offset-1 write unsequenced. This includes a second key write.
- R5: Once the locked output is 1, a correctly sequenced write to offset 1 leaves the select output unchanged and does not set the error flag.
- R6: Select codes are 00 ring oscillator, 01 main oscillator, 10 sub oscillator, and 11 prohibited. A sequenced write of 11 leaves the select output unchanged but still sets the locked output.
- R7: When the sub_osc_en input is 0, a sequenced write of code 10 is treated like code 11: the select output stays unchanged and the locked output is set.
- R8: The error flag stays at 1 until a write to offset 2 with data bit 0 equal to 0 clears it, given no unlock is pending. A write to offset 2 with bit 0 equal to 1 leaves the flag unchanged.
- R9: Read data is as follows. Offset 1 returns the locked bit in bit 7 and the select code in bits [1:0]. Offset 2 returns the error flag in bit 0. Offset 0 reads 0. All other bits read 0.
- R10: Reads (bus_we low) neither cancel a pending unlock nor change any output.
- R11: A new reset clears the select code, the locked bit and the error flag, and makes one new sequenced write possible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-on or external reset |
| bus_addr | input | 2 | Register offset: 0 command, 1 select, 2 status |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sub_osc_en | input | 1 | High when the sub oscillator is available |
| clk_sel | output | 2 | Applied clock-source code |
| sel_locked | output | 1 | One-time write used |
| prot_err | output | 1 | Sticky unlock-sequence error |

## Verification
The bound checker checks the following on every cycle:
- the select code never becomes 11, and it changes only on the clock after a commit from SEQ_ARMED;
- the locked bit never falls and freezes the select code once set;
- a bare select write always raises the error flag, while a repeat commit on a locked register never raises it;
- reads leave the sequence state and the flag untouched.

Whether a rejected code still consumes the single write is shown only by the bench's scenarios. The same holds for the sub-oscillator gating, the clear-versus-set rules of the status write, and the readback layout.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_SEL  = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_STAT = 2'd2;

    localparam logic [1:0] SRC_RING = 2'b00;
    localparam logic [1:0] SRC_MAIN = 2'b01;
    localparam logic [1:0] SRC_SUB  = 2'b10;
    localparam logic [1:0] SRC_BAD  = 2'b11;
endpackage

// File: rtl/clksel_seq_fsm.sv
module clksel_seq_fsm
    import clksel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output seq_state_t        state,
    output logic              sel_try,
    output logic              seq_err,
    output logic              err_clr
);
    seq_state_t next_state;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= next_state;
    end

    // transitions: KEY_OK, BARE_WRITE, COMMIT, ABORT
    always_comb begin
        next_state = state;
        unique case (state)
            SEQ_IDLE: begin
                if (wr_en && wr_addr == OFS_CMD && wr_data == KEY)
                    next_state = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (wr_en) next_state = SEQ_IDLE;
            end
            default: next_state = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sel_try = 1'b0;
        seq_err = 1'b0;
        err_clr = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (wr_en && wr_addr == OFS_SEL)
                    seq_err = 1'b1;
                else if (wr_en && wr_addr == OFS_STAT && !wr_data[0])
                    err_clr = 1'b1;
            end
            SEQ_ARMED: begin
                if (wr_en && wr_addr == OFS_SEL) sel_try = 1'b1;
                else if (wr_en)                 seq_err = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/clksel_sel_reg.sv
module clksel_sel_reg
    import clksel_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             try_wr,
    input  logic [SEL_W-1:0] code,
    input  logic             sub_ok,
    output logic [SEL_W-1:0] sel,
    output logic             locked
);
    logic code_ok;

    always_comb begin
        code_ok = (code != SRC_BAD) && ((code != SRC_SUB) || sub_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel    <= SRC_RING;
            locked <= 1'b0;
        end else if (try_wr && !locked) begin
            locked <= 1'b1;
            if (code_ok) sel <= code;
        end
    end
endmodule

// File: rtl/clksel_err_flag.sv
module clksel_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_err,
    input  logic clr_err,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_err) flag <= 1'b1;
        else if (clr_err) flag <= 1'b0;
    end
endmodule

// File: rtl/clksel_protect.sv
module clksel_protect
    import clksel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2,
    parameter logic [DATA_W-1:0] KEY = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sub_osc_en,
    output logic [SEL_W-1:0]  clk_sel,
    output logic              sel_locked,
    output logic              prot_err
);
    localparam int PAD_W = DATA_W - SEL_W - 1;

    seq_state_t seq_state;
    logic       sel_try, seq_err, err_clr;

    clksel_seq_fsm #(.DATA_W(DATA_W), .KEY(KEY)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
        .state(seq_state), .sel_try(sel_try),
        .seq_err(seq_err), .err_clr(err_clr)
    );

    clksel_sel_reg #(.SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .try_wr(sel_try), .code(bus_wdata[SEL_W-1:0]), .sub_ok(sub_osc_en),
        .sel(clk_sel), .locked(sel_locked)
    );

    clksel_err_flag u_err (
        .clk(clk), .rst_n(rst_n),
        .set_err(seq_err), .clr_err(err_clr), .flag(prot_err)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_SEL:  bus_rdata = {sel_locked, {PAD_W{1'b0}}, clk_sel};
            OFS_STAT: bus_rdata = {{(DATA_W-1){1'b0}}, prot_err};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/clksel_protect_chk.sv
module clksel_protect_chk
    import clksel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        clk_sel,
    input logic              locked,
    input logic              prot_err,
    input seq_state_t        state
);
    AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel != SRC_BAD); // R6

    AST_SEL_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel) |-> $past(state == SEQ_ARMED && we && addr == OFS_SEL)); // R2

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> locked); // R11

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> $stable(clk_sel)); // R5

    AST_BARE_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && we && addr == OFS_SEL) |=> prot_err); // R3

    AST_REPEAT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_ARMED && we && addr == OFS_SEL && locked && !prot_err) |=> !prot_err); // R5

    AST_ABORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_ARMED && we && addr != OFS_SEL) |=> prot_err); // R4

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(state) && $stable(prot_err))); // R10
endmodule

bind clksel_protect clksel_protect_chk u_chk (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .clk_sel(clk_sel), .locked(sel_locked), .prot_err(prot_err),
    .state(seq_state)
);

// File: tb/tb_clksel_protect.sv
module tb_clksel_protect;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sub_osc_en = 1'b1;
    logic [1:0] clk_sel;
    logic       sel_locked;
    logic       prot_err;

    int total = 0;
    int failed = 0;

    // bench model
    logic [1:0] m_sel;
    logic       m_lock, m_err, m_armed;

    always #(CLK_PERIOD/2) clk = ~clk;

    clksel_protect dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_osc_en(sub_osc_en),
        .clk_sel(clk_sel), .sel_locked(sel_locked), .prot_err(prot_err)
    );

    function automatic logic code_ok(input logic [1:0] c, input logic sub);
        return (c != 2'b11) && (c != 2'b10 || sub);
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd1:    return {m_lock, 5'b0, m_sel};
            2'd2:    return {7'b0, m_err};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        check({tag, " sel"},  {6'b0, clk_sel}, {6'b0, m_sel});
        check({tag, " lock"}, {7'b0, sel_locked}, {7'b0, m_lock});
        check({tag, " err"},  {7'b0, prot_err}, {7'b0, m_err});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        m_sel = 2'b00; m_lock = 1'b0; m_err = 1'b0; m_armed = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        if (m_armed) begin
            m_armed = 1'b0;
            if (a == 2'd1) begin
                if (!m_lock) begin
                    m_lock = 1'b1;
                    if (code_ok(d[1:0], sub_osc_en)) m_sel = d[1:0];
                end
            end else begin
                m_err = 1'b1;
            end
        end else if (a == 2'd0 && d == 8'hA5) begin
            m_armed = 1'b1;
        end else if (a == 2'd1) begin
            m_err = 1'b1;
        end else if (a == 2'd2 && !d[0]) begin
            m_err = 1'b0;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        model_write(a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a);
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();
        check_outs("R1 reset");

        // R3: bare write
        wr(2'd1, 8'h01);
        check_outs("R3 bare write");

        // R8: clear rules
        wr(2'd2, 8'h01);
        check_outs("R8 status bit0=1 keeps");
        wr(2'd2, 8'h00);
        check_outs("R8 status bit0=0 clears");

        // R4: abort by status write, then unsequenced select write
        wr(2'd0, 8'hA5);
        wr(2'd2, 8'h00);
        check_outs("R4 abort via status");
        wr(2'd1, 8'h01);
        check_outs("R4 no sequence after abort");
        wr(2'd2, 8'h00);

        // R4: second key aborts
        wr(2'd0, 8'hA5);
        wr(2'd0, 8'hA5);
        check_outs("R4 double key");
        wr(2'd2, 8'h00);

        // R10 + R2: reads between key and commit
        wr(2'd0, 8'hA5);
        rd_check("R10 read offset 2", 2'd2);
        rd_check("R10 read offset 0", 2'd0);
        wr(2'd1, 8'hFD);
        check_outs("R2 commit main");

        // R5: repeat ignored without error
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h02);
        check_outs("R5 repeat ignored");

        // R9 readback
        rd_check("R9 read offset 1", 2'd1);
        rd_check("R9 read offset 2", 2'd2);
        rd_check("R9 read offset 0", 2'd0);
        rd_check("R9 read offset 3", 2'd3);

        // R11, R6: prohibited code consumes lock
        do_reset();
        check_outs("R11 reset clears");
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h03);
        check_outs("R6 code 11 rejected");
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h01);
        check_outs("R6 lock consumed");

        // R7: sub oscillator gating
        do_reset();
        sub_osc_en = 1'b0;
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h02);
        check_outs("R7 sub disabled");
        do_reset();
        sub_osc_en = 1'b1;
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h02);
        check_outs("R6 sub selected");
        rd_check("R9 read sub", 2'd1);

        // random phase
        do_reset();
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom % 9;
            sub_osc_en = $urandom % 4 != 0;
            case (op)
                0, 1: wr(2'd0, 8'hA5);
                2, 3: wr(2'd1, 8'($urandom));
                4:    wr(2'd2, 8'($urandom));
                5:    wr(2'd0, 8'($urandom));
                6:    wr(2'd3, 8'($urandom));
                7:    rd_check("R9 random read", 2'($urandom));
                default: if ($urandom % 10 == 0) do_reset();
            endcase
            check_outs("random");
        end

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule